// File: doc/BRIEF.md
# Boot-Remapping Address Decoder

This block sits beside a system bus and does two things. It turns the upper twelve bits of a bus address into a one-hot slave select across up to 32 address windows, or raises a miss flag when no window covers the address. It also owns the boot remap. After reset the ROM slave (slot 4) covers the boot address. When software sets the remap bit, the RAM slave (slot 6) moves onto the ROM's old base and the ROM moves to just above the end of the RAM window. The remap is one-way and only a reset undoes it.

Every window is set at build time by a parameter word per slot. Bits 31:20 of that word give the base in 1 MB units, and bits 19:16 give a size code, where the window spans 2^code MB. A 32-bit register port, word-addressed inside a 4 KB space, reads back the windows and gives access to the control, priority, idle-count and revision words. Only the ROM and RAM bases change at run time. The decoder always compares against the bases in force at that moment.

Top module: `ahb_remap_decoder`

## Requirements
- R1: Slot n's word is at offset 4*n. For every slot other than 4 and 6, a read returns the configured word unchanged. Writes to any slot offset have no effect.
- R2: Reads of slot 4 (offset 0x010) and slot 6 (offset 0x018) return the live base in bits 31:20, the configured size code in bits 19:16, and zero in bits 15:0.
- R3: Offset 0x08C always reads 0x00010301.
- R4: Writing 1 to bit 0 of the control word (offset 0x088) while remap is off takes effect in the next cycle. The RAM base becomes the ROM's base before the write. The ROM base becomes that value plus 2^(RAM size code), counted in 1 MB units modulo 4096.
- R5: The control word reads remap state in bit 0 and zero in all other bits. Once remap is on, no write turns it off.
- R6: Writing 0 to control bit 0 while remap is on sets remap_err from the next cycle. remap_err then stays set until reset. The same write while remap is off leaves remap_err clear.
- R7: Offsets 0x080 and 0x084 are plain 32-bit read/write words with no side effect.
- R8: Slot i matches when dec_page and slot i's live base agree in every bit above the low (size code) bits. dec_sel shows only the lowest-numbered matching slot, and it does so in the same cycle as dec_page.
- R9: Offsets with bits 1:0 not zero, and offsets above 0x08C, read zero. Writes to them change nothing.
- R10: When no slot matches, dec_miss is 1 and dec_sel is all zero. Otherwise dec_miss is 0.
- R11: Reset restores the configured ROM and RAM bases, turns remap off, and clears remap_err, the control word and both words at 0x080 and 0x084.
- R12: In the cycle that carries the remap write, the decoder still uses the bases from before the remap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 12 | Register byte offset |
| reg_we | input | 1 | Write strobe for the register port |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| dec_page | input | 12 | Bus address bits 31:20 to decode |
| dec_sel | output | NUM_SLAVES | One-hot slave select |
| dec_miss | output | 1 | No window covers dec_page |
| remap_err | output | 1 | Sticky flag: a write tried to clear remap |

## Verification
The remap write and an address decode can occur in the same cycle. The decode must then use the old windows, and the next decode must use the new ones. The bench provokes this on purpose: it issues the remap write while dec_page points at the boot page, and then keeps the page there for the following cycle. A long random stream also mixes control writes with decodes near every base. A behavioural model, updated only at the clock edge, predicts the select and read data for every cycle. The bench compares them before the edge, so a decoder that looked ahead at the next-state bases would show up as a miscompare.

// File: rtl/ahbdec_pkg.sv
package ahbdec_pkg;

    localparam int MAX_SLAVES = 32;
    localparam int BASE_W     = 12;
    localparam int CODE_W     = 4;
    localparam int IDX_W      = $clog2(MAX_SLAVES);

    localparam logic [11:0] OFF_PRIO = 12'h080;
    localparam logic [11:0] OFF_IDLE = 12'h084;
    localparam logic [11:0] OFF_CTRL = 12'h088;
    localparam logic [11:0] OFF_REV  = 12'h08C;
    localparam logic [31:0] REV_ID   = 32'h0001_0301;

    typedef logic [BASE_W-1:0] base_t;
    typedef logic [CODE_W-1:0] code_t;
    typedef logic [MAX_SLAVES-1:0][31:0] map_t;

    // Default window map: 16 MB windows from 0x100 upward, a 32 MB
    // window in slot 1 that overlaps slots 2 and 3, the ROM at 0 (4 MB)
    // and the RAM at 0x400 (8 MB).
    function automatic map_t default_map();
        map_t m;
        for (int n = 0; n < MAX_SLAVES; n++) begin
            m[n] = {base_t'(32'h100 + n * 16), code_t'(4), 16'h0000};
        end
        m[1] = {base_t'(12'h120), code_t'(5), 16'h0000};
        m[4] = {base_t'(12'h000), code_t'(2), 16'h0000};
        m[6] = {base_t'(12'h400), code_t'(3), 16'h0000};
        return m;
    endfunction

    function automatic base_t window_mask(code_t c);
        return base_t'({BASE_W{1'b1}} << c);
    endfunction

endpackage

// File: rtl/ahbdec_match.sv
module ahbdec_match
    import ahbdec_pkg::*;
#(
    parameter int NUM_SLAVES = MAX_SLAVES
) (
    input  base_t                  page,
    input  base_t [NUM_SLAVES-1:0] win_base,
    input  code_t [NUM_SLAVES-1:0] win_code,
    output logic  [NUM_SLAVES-1:0] dec_sel,
    output logic                   dec_miss
);

    logic [NUM_SLAVES-1:0] hit;

    for (genvar g = 0; g < NUM_SLAVES; g++) begin : g_win
        assign hit[g] = ((page ^ win_base[g]) & window_mask(win_code[g])) == '0;
    end

    // isolate lowest set bit: lowest slot number wins on overlap
    assign dec_sel  = hit & ((~hit) + NUM_SLAVES'(1));
    assign dec_miss = ~|hit;

endmodule

// File: rtl/ahbdec_regs.sv
module ahbdec_regs
    import ahbdec_pkg::*;
#(
    parameter int   NUM_SLAVES = MAX_SLAVES,
    parameter int   ROM_SLOT   = 4,
    parameter int   RAM_SLOT   = 6,
    parameter map_t SLAVE_CFG  = default_map()
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [11:0]            reg_addr,
    input  logic                   reg_we,
    input  logic [31:0]            reg_wdata,
    output logic [31:0]            reg_rdata,
    output base_t [NUM_SLAVES-1:0] win_base,
    output code_t [NUM_SLAVES-1:0] win_code,
    output logic                   remap_on,
    output logic                   remap_err
);

    localparam base_t ROM_RST  = SLAVE_CFG[ROM_SLOT][31:20];
    localparam base_t RAM_RST  = SLAVE_CFG[RAM_SLOT][31:20];
    localparam code_t RAM_CODE = SLAVE_CFG[RAM_SLOT][19:16];
    localparam logic [IDX_W-1:0] ROM_IDX = IDX_W'(ROM_SLOT);
    localparam logic [IDX_W-1:0] RAM_IDX = IDX_W'(RAM_SLOT);

    typedef struct packed {
        base_t       rom_base;
        base_t       ram_base;
        logic        remap;
        logic        err;
        logic [31:0] prio;
        logic [31:0] idle;
    } ctl_t;

    localparam ctl_t CTL_RST = '{
        rom_base: ROM_RST,
        ram_base: RAM_RST,
        remap:    1'b0,
        err:      1'b0,
        prio:     32'h0,
        idle:     32'h0
    };

    ctl_t st_d, st_q;

    logic [9:0]       word_d;
    logic [IDX_W-1:0] slot_d;
    logic             aligned_d;

    for (genvar g = 0; g < NUM_SLAVES; g++) begin : g_live
        if (g == ROM_SLOT) begin : g_rom
            assign win_base[g] = st_q.rom_base;
        end else if (g == RAM_SLOT) begin : g_ram
            assign win_base[g] = st_q.ram_base;
        end else begin : g_fixed
            assign win_base[g] = SLAVE_CFG[g][31:20];
        end
        assign win_code[g] = SLAVE_CFG[g][19:16];
    end

    always_comb begin
        st_d      = st_q;
        reg_rdata = 32'h0;
        word_d    = reg_addr[11:2];
        slot_d    = reg_addr[IDX_W+1:2];
        aligned_d = (reg_addr[1:0] == 2'b00);

        // next state
        if (reg_we && aligned_d) begin
            case (reg_addr)
                OFF_PRIO: st_d.prio = reg_wdata;
                OFF_IDLE: st_d.idle = reg_wdata;
                OFF_CTRL: begin
                    if (reg_wdata[0] && !st_q.remap) begin
                        st_d.ram_base = st_q.rom_base;
                        st_d.rom_base = st_q.rom_base + (base_t'(1) << RAM_CODE);
                        st_d.remap    = 1'b1;
                    end else if (!reg_wdata[0] && st_q.remap) begin
                        st_d.err = 1'b1;
                    end
                end
                default: ;
            endcase
        end

        // read mux
        if (aligned_d) begin
            if (int'(word_d) < NUM_SLAVES) begin
                if (slot_d == ROM_IDX || slot_d == RAM_IDX) begin
                    reg_rdata = {win_base[slot_d], win_code[slot_d], 16'h0000};
                end else begin
                    reg_rdata = SLAVE_CFG[slot_d];
                end
            end else begin
                case (reg_addr)
                    OFF_PRIO: reg_rdata = st_q.prio;
                    OFF_IDLE: reg_rdata = st_q.idle;
                    OFF_CTRL: reg_rdata = {31'h0, st_q.remap};
                    OFF_REV:  reg_rdata = REV_ID;
                    default:  reg_rdata = 32'h0;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= CTL_RST;
        else        st_q <= st_d;
    end

    assign remap_on  = st_q.remap;
    assign remap_err = st_q.err;

endmodule

// File: rtl/ahb_remap_decoder.sv
module ahb_remap_decoder
    import ahbdec_pkg::*;
#(
    parameter int   NUM_SLAVES = MAX_SLAVES,
    parameter int   ROM_SLOT   = 4,
    parameter int   RAM_SLOT   = 6,
    parameter map_t SLAVE_CFG  = default_map()
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [11:0]           reg_addr,
    input  logic                  reg_we,
    input  logic [31:0]           reg_wdata,
    output logic [31:0]           reg_rdata,
    input  logic [11:0]           dec_page,
    output logic [NUM_SLAVES-1:0] dec_sel,
    output logic                  dec_miss,
    output logic                  remap_err
);

    base_t [NUM_SLAVES-1:0] win_base;
    code_t [NUM_SLAVES-1:0] win_code;
    logic                   remap_on;

    ahbdec_regs #(
        .NUM_SLAVES (NUM_SLAVES),
        .ROM_SLOT   (ROM_SLOT),
        .RAM_SLOT   (RAM_SLOT),
        .SLAVE_CFG  (SLAVE_CFG)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .win_base  (win_base),
        .win_code  (win_code),
        .remap_on  (remap_on),
        .remap_err (remap_err)
    );

    ahbdec_match #(
        .NUM_SLAVES (NUM_SLAVES)
    ) u_match (
        .page     (dec_page),
        .win_base (win_base),
        .win_code (win_code),
        .dec_sel  (dec_sel),
        .dec_miss (dec_miss)
    );

endmodule

// File: rtl/ahbdec_checker.sv
module ahbdec_checker
    import ahbdec_pkg::*;
#(
    parameter int NUM_SLAVES = MAX_SLAVES
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [11:0]           reg_addr,
    input logic                  reg_we,
    input logic                  wr_bit0,
    input logic [31:0]           reg_rdata,
    input logic [NUM_SLAVES-1:0] dec_sel,
    input logic                  dec_miss,
    input logic                  remap_on,
    input logic                  remap_err
);

    logic ctrl_wr;
    assign ctrl_wr = reg_we && (reg_addr == OFF_CTRL);

    assert_rev_const_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == OFF_REV) |-> (reg_rdata == REV_ID));

    assert_remap_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(remap_on) |-> $past(ctrl_wr && wr_bit0));

    assert_remap_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        remap_on |=> remap_on);

    assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        remap_err |=> remap_err);

    assert_err_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(remap_err) |-> $past(ctrl_wr && !wr_bit0 && remap_on));

    assert_sel_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dec_sel));

    assert_miss_agree_R10: assert property (@(posedge clk) disable iff (!rst_n)
        dec_miss == (dec_sel == '0));

endmodule

bind ahb_remap_decoder ahbdec_checker #(.NUM_SLAVES(NUM_SLAVES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_we    (reg_we),
    .wr_bit0   (reg_wdata[0]),
    .reg_rdata (reg_rdata),
    .dec_sel   (dec_sel),
    .dec_miss  (dec_miss),
    .remap_on  (remap_on),
    .remap_err (remap_err)
);

// File: tb/tb_ahb_remap_decoder.sv
module tb_ahb_remap_decoder;
    import ahbdec_pkg::*;

    localparam int   NS   = 32;
    localparam int   ROMI = 4;
    localparam int   RAMI = 6;
    localparam map_t CFG  = default_map();

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [11:0] dec_page = '0;
    logic [NS-1:0] dec_sel;
    logic        dec_miss;
    logic        remap_err;

    int vectors = 0;
    int fails   = 0;
    bit done    = 0;

    // model state
    int          m_rom, m_ram;
    bit          m_remap, m_err;
    logic [31:0] m_prio, m_idle;

    // last sampled outputs
    logic [31:0] s_rdata;
    logic [31:0] s_sel;
    logic        s_err;

    always #2 clk = ~clk;

    ahb_remap_decoder dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .dec_page  (dec_page),
        .dec_sel   (dec_sel),
        .dec_miss  (dec_miss),
        .remap_err (remap_err)
    );

    function automatic void model_reset();
        m_rom   = int'(CFG[ROMI][31:20]);
        m_ram   = int'(CFG[RAMI][31:20]);
        m_remap = 0;
        m_err   = 0;
        m_prio  = 0;
        m_idle  = 0;
    endfunction

    function automatic int base_of(int i);
        if (i == ROMI) return m_rom;
        if (i == RAMI) return m_ram;
        return int'(CFG[i][31:20]);
    endfunction

    function automatic int model_hit(int pg);
        for (int i = 0; i < NS; i++) begin
            int sz, start;
            sz    = 1 << int'(CFG[i][19:16]);
            start = (base_of(i) / sz) * sz;
            if (pg >= start && pg < start + sz) return i;
        end
        return -1;
    endfunction

    function automatic logic [31:0] model_read(logic [11:0] a);
        int w;
        if (a[1:0] != 2'b00) return 32'h0;
        w = int'(a) / 4;
        if (w < NS) begin
            if (w == ROMI || w == RAMI)
                return {base_t'(base_of(w)), CFG[w][19:16], 16'h0};
            return CFG[w];
        end
        case (a)
            12'h080: return m_prio;
            12'h084: return m_idle;
            12'h088: return {31'h0, m_remap};
            12'h08C: return 32'h0001_0301;
            default: return 32'h0;
        endcase
    endfunction

    function automatic void model_write(logic [11:0] a, logic [31:0] d);
        if (a == 12'h080) m_prio = d;
        else if (a == 12'h084) m_idle = d;
        else if (a == 12'h088) begin
            if (d[0] && !m_remap) begin
                m_ram   = m_rom;
                m_rom   = (m_ram + (1 << int'(CFG[RAMI][19:16]))) % 4096;
                m_remap = 1;
            end else if (!d[0] && m_remap) begin
                m_err = 1;
            end
        end
    endfunction

    function automatic string tag_of(logic [11:0] a);
        int w;
        if (a[1:0] != 2'b00) return "R9";
        w = int'(a) / 4;
        if (w == ROMI || w == RAMI) return "R2";
        if (w < NS) return "R1";
        if (a == 12'h080 || a == 12'h084) return "R7";
        if (a == 12'h088) return "R5";
        if (a == 12'h08C) return "R3";
        return "R9";
    endfunction

    task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%08h expected=%08h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input logic [11:0] a, input logic we, input logic [31:0] d,
                        input logic [11:0] pg);
        int h;
        logic [31:0] esel;
        @(negedge clk);
        reg_addr  = a;
        reg_we    = we;
        reg_wdata = d;
        dec_page  = pg;
        #1;
        h    = model_hit(int'(pg));
        esel = (h < 0) ? 32'h0 : (32'h1 << h);
        s_rdata = reg_rdata;
        s_sel   = dec_sel;
        s_err   = remap_err;
        cmp(tag_of(a), reg_rdata, model_read(a));
        cmp("R8", dec_sel, esel);
        cmp("R10", {31'h0, dec_miss}, {31'h0, (h < 0)});
        cmp("R6", {31'h0, remap_err}, {31'h0, m_err});
        @(posedge clk);
        if (rst_n && we) model_write(a, d);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n  = 1'b0;
        reg_we = 1'b0;
        repeat (2) @(negedge clk);
        model_reset();
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog (all) actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        model_reset();
        do_reset();

        // R11: reset state
        step(12'h088, 0, 0, 12'h000);
        cmp("R11", s_rdata, 32'h0);
        step(12'h080, 0, 0, 12'h000);
        cmp("R11", s_rdata, 32'h0);
        step(12'h018, 0, 0, 12'h000);
        cmp("R11", s_rdata, 32'h4003_0000);

        // R1/R2: every slot word
        for (int i = 0; i < NS; i++) step(12'(i * 4), 0, 0, 12'h000);
        step(12'h08C, 0, 0, 12'h000);                    // R3

        // R7 storage
        step(12'h080, 1, 32'hA5A5_5A5A, 12'h000);
        step(12'h084, 1, 32'h1234_5678, 12'h000);
        step(12'h080, 0, 0, 12'h000);
        cmp("R7", s_rdata, 32'hA5A5_5A5A);

        // R9: unmapped and misaligned writes change nothing
        step(12'h090, 1, 32'hFFFF_FFFF, 12'h000);
        step(12'hFFC, 1, 32'hFFFF_FFFF, 12'h000);
        step(12'h081, 1, 32'hFFFF_FFFF, 12'h000);
        step(12'h089, 1, 32'hFFFF_FFFF, 12'h000);
        step(12'h080, 0, 0, 12'h000);
        cmp("R9", s_rdata, 32'hA5A5_5A5A);
        step(12'h088, 0, 0, 12'h000);
        cmp("R9", s_rdata, 32'h0);

        // R1: slot write ignored
        step(12'h004, 1, 32'h0, 12'h000);
        step(12'h004, 0, 0, 12'h000);
        cmp("R1", s_rdata, 32'h1205_0000);

        // R8/R10 decode patterns
        step(12'h000, 0, 0, 12'h000);
        cmp("R8", s_sel, 32'h1 << 4);
        step(12'h000, 0, 0, 12'h403);
        cmp("R8", s_sel, 32'h1 << 6);
        step(12'h000, 0, 0, 12'h130);
        cmp("R8", s_sel, 32'h1 << 1);                    // overlap: lowest wins
        step(12'h000, 0, 0, 12'h110);
        cmp("R10", s_sel, 32'h0);
        step(12'h000, 0, 0, 12'h2F7);
        cmp("R8", s_sel, 32'h1 << 31);

        // R6: clearing while off raises nothing
        step(12'h088, 1, 32'h0, 12'h000);
        step(12'h088, 0, 0, 12'h000);
        cmp("R6", {31'h0, s_err}, 32'h0);

        // R12 then R4
        step(12'h088, 1, 32'h1, 12'h000);
        cmp("R12", s_sel, 32'h1 << 4);
        step(12'h018, 0, 0, 12'h000);
        cmp("R4", s_sel, 32'h1 << 6);
        cmp("R4", s_rdata, 32'h0003_0000);
        step(12'h010, 0, 0, 12'h008);
        cmp("R4", s_rdata, 32'h0082_0000);
        cmp("R4", s_sel, 32'h1 << 4);
        step(12'h000, 0, 0, 12'h400);
        cmp("R10", s_sel, 32'h0);

        // R5 and R6
        step(12'h088, 1, 32'hFFFF_FFFF, 12'h000);
        step(12'h088, 0, 0, 12'h000);
        cmp("R5", s_rdata, 32'h1);
        step(12'h088, 1, 32'h0, 12'h000);
        step(12'h088, 0, 0, 12'h000);
        cmp("R5", s_rdata, 32'h1);
        cmp("R6", {31'h0, s_err}, 32'h1);
        step(12'h088, 1, 32'h1, 12'h000);
        step(12'h088, 0, 0, 12'h000);
        cmp("R6", {31'h0, s_err}, 32'h1);

        // R11 after remap
        do_reset();
        step(12'h018, 0, 0, 12'h000);
        cmp("R11", s_rdata, 32'h4003_0000);
        cmp("R11", {31'h0, s_err}, 32'h0);
        cmp("R11", s_sel, 32'h1 << 4);
        step(12'h084, 0, 0, 12'h000);
        cmp("R11", s_rdata, 32'h0);

        // random mix
        for (int n = 0; n < 4000; n++) begin
            int unsigned k;
            logic [11:0] a;
            logic [31:0] d;
            logic [11:0] pg;
            logic        we;
            k = $urandom % 8;
            case (k)
                0: a = 12'(($urandom % NS) * 4);
                1: a = 12'h080;
                2: a = 12'h084;
                3: a = 12'h088;
                4: a = 12'h08C;
                5: a = 12'(12'h090 + ($urandom % 988) * 4);
                6: a = 12'(($urandom % 36) * 4 + 1 + ($urandom % 3));
                default: a = ($urandom % 2) ? 12'h010 : 12'h018;
            endcase
            we = 1'($urandom % 2);
            d  = $urandom;
            if (a == 12'h088) d[0] = (($urandom % 8) != 0);
            if ($urandom % 2) pg = 12'($urandom);
            else pg = 12'(base_of(int'($urandom % NS)) + int'($urandom % 40));
            step(a, we, d, pg);
            if (n % 700 == 699) do_reset();
        end

        done = 1;
        finish_run();
    end

endmodule